// File: doc/BRIEF.md
# Persistent-Memory Bank Command Handler

This block is the command-side state keeper for a memory device whose cells keep their contents without power and whose reads leave the cells untouched. It takes one decoded DDR4-style command per clock: activate, read, write, precharge, precharge-all, refresh, self-refresh entry and self-refresh exit. Each command carries a bank number and either a row or a column. The block keeps the open row of every bank. It then decides, for every read or write, whether the access may go on to the data path.

Capacitor-DRAM housekeeping has no effect here. Precharge and refresh are accepted and do nothing. A row stays open until a later activate to that bank names a different row. A uniform activate-to-activate gap and a uniform column-to-column gap apply to every pair of banks. There is no window that limits the count of activates and no grouping of banks. Self-refresh serves only as a quiet state for changing the clock frequency: it refuses work and leaves every open row in place.

An accepted read or write leaves the block one cycle after its command. It carries the bank, the row held open in that bank, the column and the direction. A command that is refused raises exactly one error pulse in that same cycle instead.

Top module: `nvm_bank_cmd`

## Requirements
- R1: After reset no bank has an open row and every output is low. A read or write to a bank not activated since reset raises err_unopened and is not forwarded.
- R2: An accepted read or write produces acc_valid one cycle after the command, together with acc_bank, the bank's open row on acc_row, acc_col and acc_write (1 for write).
- R3: Precharge, precharge-all and refresh produce no output and no error and leave every open row unchanged. A column command that follows them at once is forwarded, so refresh costs no recovery time.
- R4: An activate naming a row other than the open one replaces it and restarts the activate-to-column delay. An activate naming the already open row leaves the row and the delay state unchanged.
- R5: A read or write issued fewer than T_RCD cycles after the row-changing activate of its bank raises err_timing and is not forwarded. At exactly T_RCD cycles it is forwarded.
- R6: An activate issued fewer than T_RRD cycles after the previous accepted activate, to any bank, raises err_spacing and is ignored. The gap is the same for every pair of banks, and any number of activates at that gap are all accepted.
- R7: A read or write issued fewer than T_CCD cycles after the previous forwarded read or write, to any bank, raises err_spacing and is not forwarded.
- R8: Self-refresh entry sets the quiet mode. While in it, every command except self-refresh exit raises err_mode and has no effect. An exit outside the mode also raises err_mode. After exit, all open rows are intact.
- R9: When a command breaks several rules, exactly one error is raised, with this precedence: err_mode, then err_unopened, then err_timing, then err_spacing.
- R10: The cmd_op codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREA=5, REF=6, SRE=7, SRX=8. Any other code behaves as NOP. The column field is log2(PAGE_BYTES/COL_BYTES) bits wide (10 by default, giving an 8 KB page) and is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 4 | Command code, one command per cycle |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Row address for activate |
| cmd_col | input | COL_W | Column within the open page for read or write |
| acc_valid | output | 1 | Forwarded access strobe |
| acc_write | output | 1 | Forwarded access is a write |
| acc_bank | output | BANK_W | Bank of the forwarded access |
| acc_row | output | ROW_W | Open row of that bank |
| acc_col | output | COL_W | Column of the forwarded access |
| err_mode | output | 1 | Command not allowed in the present power mode |
| err_unopened | output | 1 | Column command to a bank with no open row |
| err_timing | output | 1 | Column command before activate-to-column delay |
| err_spacing | output | 1 | Activate or column command too close to the previous one |

## Verification
A stale or corrupted open row appears on acc_row with the very next forwarded read to that bank, one cycle after the read command. That makes precharge, refresh and self-refresh round trips cheap to check by reading straight after them. A delay counter that is wrong by one cycle turns the boundary column command into err_timing, or lets the command before the boundary through. The bench therefore probes both sides of each gap. A mode flag that is stuck shows on the next command as a spurious or missing err_mode.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ACT  = 4'd1,
    OP_RD   = 4'd2,
    OP_WR   = 4'd3,
    OP_PRE  = 4'd4,
    OP_PREA = 4'd5,
    OP_REF  = 4'd6,
    OP_SRE  = 4'd7,
    OP_SRX  = 4'd8
  } cmd_op_e;

  typedef enum logic [2:0] {
    RES_NONE    = 3'd0,
    RES_FWD     = 3'd1,
    RES_MODE    = 3'd2,
    RES_UNOPEN  = 3'd3,
    RES_TIMING  = 3'd4,
    RES_SPACING = 3'd5
  } result_e;

  // Column field width for a page split into fixed-size columns.
  function automatic int col_bits(input int page_bytes, input int col_bytes);
    return $clog2(page_bytes / col_bytes);
  endfunction

  // Counter width able to hold gap-1.
  function automatic int gap_bits(input int gap);
    return (gap < 2) ? 1 : $clog2(gap);
  endfunction

  // Outcome of one command; the order of tests is the error precedence.
  function automatic result_e classify(
    input logic in_sr,
    input logic known,
    input logic is_srx,
    input logic is_col,
    input logic is_act,
    input logic bank_open,
    input logic rcd_ok,
    input logic ccd_ok,
    input logic rrd_ok
  );
    logic bad_mode;
    bad_mode = in_sr ? (known && !is_srx) : is_srx;
    if (bad_mode)                                      return RES_MODE;
    else if (is_col && !bank_open)                     return RES_UNOPEN;
    else if (is_col && !rcd_ok)                        return RES_TIMING;
    else if ((is_col && !ccd_ok) || (is_act && !rrd_ok)) return RES_SPACING;
    else if (is_col)                                   return RES_FWD;
    else                                               return RES_NONE;
  endfunction

endpackage

// File: rtl/nvm_gap_timer.sv
module nvm_gap_timer
  import nvm_cmd_pkg::*;
#(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int CW = gap_bits(GAP);
  localparam logic [CW-1:0] LOADV = CW'(GAP - 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (start)          count <= LOADV;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign ready = (count == '0);

  generate
    if (GAP > 1) begin : g_chk
      AST_GAP_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);  // R5 R6 R7
    end
  endgenerate

endmodule

// File: rtl/nvm_bank_slot.sv
module nvm_bank_slot #(
  parameter int ROW_W = 16,
  parameter int T_RCD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  logic [ROW_W-1:0] act_row,
  output logic             open_vld,
  output logic [ROW_W-1:0] open_row,
  output logic             col_ok
);
  logic row_change;

  assign row_change = act_en && (!open_vld || (act_row != open_row));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_vld <= 1'b0;
      open_row <= '0;
    end else if (row_change) begin
      open_vld <= 1'b1;
      open_row <= act_row;
    end
  end

  nvm_gap_timer #(.GAP(T_RCD)) u_rcd (
    .clk   (clk),
    .rst_n (rst_n),
    .start (row_change),
    .ready (col_ok)
  );

  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> ($stable(open_row) && $stable(open_vld)));  // R3
  AST_SAME_ROW_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && open_vld && (act_row == open_row) && col_ok) |=> col_ok);  // R4

endmodule

// File: rtl/nvm_sr_mode.sv
module nvm_sr_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic in_sr
);
  always_ff @(posedge clk) begin
    if (!rst_n)     in_sr <= 1'b0;
    else if (enter) in_sr <= 1'b1;
    else if (leave) in_sr <= 1'b0;
  end

  AST_SR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sr && !leave) |=> in_sr);  // R8

endmodule

// File: rtl/nvm_bank_cmd.sv
module nvm_bank_cmd
  import nvm_cmd_pkg::*;
#(
  parameter int NUM_BANKS  = 16,
  parameter int ROW_W      = 16,
  parameter int PAGE_BYTES = 8192,
  parameter int COL_BYTES  = 8,
  parameter int T_RCD      = 4,
  parameter int T_RRD      = 2,
  parameter int T_CCD      = 2,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int COL_W     = col_bits(PAGE_BYTES, COL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  output logic              acc_valid,
  output logic              acc_write,
  output logic [BANK_W-1:0] acc_bank,
  output logic [ROW_W-1:0]  acc_row,
  output logic [COL_W-1:0]  acc_col,
  output logic              err_mode,
  output logic              err_unopened,
  output logic              err_timing,
  output logic              err_spacing
);
  cmd_op_e op;
  logic    is_act, is_col, is_sre, is_srx, is_known, is_idle_cmd;
  logic    in_sr, rrd_ok, ccd_ok;
  logic    sel_open, sel_rcd_ok;
  logic    act_go, col_go, sre_go, srx_go;
  result_e res;

  logic             bank_vld    [NUM_BANKS];
  logic [ROW_W-1:0] bank_row    [NUM_BANKS];
  logic             bank_rcd_ok [NUM_BANKS];

  assign op = cmd_op_e'(cmd_op);

  always_comb begin
    is_act      = (op == OP_ACT);
    is_col      = (op == OP_RD) || (op == OP_WR);
    is_sre      = (op == OP_SRE);
    is_srx      = (op == OP_SRX);
    is_idle_cmd = (op == OP_PRE) || (op == OP_PREA) || (op == OP_REF);
    is_known    = (cmd_op >= 4'd1) && (cmd_op <= 4'd8);
  end

  assign sel_open   = bank_vld[cmd_bank];
  assign sel_rcd_ok = bank_rcd_ok[cmd_bank];

  assign res = classify(in_sr, is_known, is_srx, is_col, is_act,
                        sel_open, sel_rcd_ok, ccd_ok, rrd_ok);

  assign act_go = is_act && (res == RES_NONE);
  assign col_go = (res == RES_FWD);
  assign sre_go = is_sre && (res == RES_NONE);
  assign srx_go = is_srx && (res == RES_NONE);

  // One open-row slot per bank; precharge and refresh never reach them.
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      nvm_bank_slot #(.ROW_W(ROW_W), .T_RCD(T_RCD)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_en   (act_go && (cmd_bank == BANK_W'(b))),
        .act_row  (cmd_row),
        .open_vld (bank_vld[b]),
        .open_row (bank_row[b]),
        .col_ok   (bank_rcd_ok[b])
      );
    end
  endgenerate

  // Device-wide gaps, identical for every pair of banks.
  nvm_gap_timer #(.GAP(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .start(act_go), .ready(rrd_ok)
  );
  nvm_gap_timer #(.GAP(T_CCD)) u_ccd (
    .clk(clk), .rst_n(rst_n), .start(col_go), .ready(ccd_ok)
  );

  nvm_sr_mode u_mode (
    .clk(clk), .rst_n(rst_n), .enter(sre_go), .leave(srx_go), .in_sr(in_sr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid    <= 1'b0;
      acc_write    <= 1'b0;
      acc_bank     <= '0;
      acc_row      <= '0;
      acc_col      <= '0;
      err_mode     <= 1'b0;
      err_unopened <= 1'b0;
      err_timing   <= 1'b0;
      err_spacing  <= 1'b0;
    end else begin
      acc_valid    <= col_go;
      err_mode     <= (res == RES_MODE);
      err_unopened <= (res == RES_UNOPEN);
      err_timing   <= (res == RES_TIMING);
      err_spacing  <= (res == RES_SPACING);
      if (col_go) begin
        acc_write <= (op == OP_WR);
        acc_bank  <= cmd_bank;
        acc_row   <= bank_row[cmd_bank];
        acc_col   <= cmd_col;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_valid, err_mode, err_unopened, err_timing, err_spacing}));  // R9
  AST_UNOPEN_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && !sel_open) |=> !acc_valid);  // R1
  AST_IDLE_CMD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle_cmd && !in_sr) |=> !(acc_valid || err_mode || err_unopened || err_timing || err_spacing));  // R3
  AST_SR_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |=> !acc_valid);  // R8

endmodule

// File: tb/tb_nvm_bank_cmd.sv
module tb_nvm_bank_cmd;

  localparam int E_NONE = 0, E_FWD = 1, E_MODE = 2, E_UNOP = 3, E_TIME = 4, E_SPAC = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cmd_op;
  logic [3:0]  cmd_bank;
  logic [15:0] cmd_row;
  logic [9:0]  cmd_col;
  logic        acc_valid, acc_write;
  logic [3:0]  acc_bank;
  logic [15:0] acc_row;
  logic [9:0]  acc_col;
  logic        err_mode, err_unopened, err_timing, err_spacing;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nvm_bank_cmd dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_bank(acc_bank), .acc_row(acc_row),
    .acc_col(acc_col), .err_mode(err_mode), .err_unopened(err_unopened),
    .err_timing(err_timing), .err_spacing(err_spacing)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  bank;
    logic [15:0] row;
    logic [9:0]  col;
    logic [2:0]  kind;
    logic [15:0] erow;
    logic [7:0]  req;
  } vec_t;

  // One command per cycle; expected outcome seen one cycle later.
  localparam vec_t VEC [30] = '{
    '{4'd2, 4'd0, 16'h0000, 10'd5,   3'd3, 16'h0000, 8'd1},  // R1 read unopened
    '{4'd3, 4'd3, 16'h0000, 10'd5,   3'd3, 16'h0000, 8'd1},  // R1 write unopened
    '{4'd1, 4'd0, 16'h1234, 10'd0,   3'd0, 16'h0000, 8'd2},  // R2 open bank0
    '{4'd1, 4'd1, 16'h0042, 10'd0,   3'd5, 16'h0000, 8'd6},  // R6 act gap 1
    '{4'd1, 4'd1, 16'h0042, 10'd0,   3'd0, 16'h0000, 8'd6},  // R6 act gap 2
    '{4'd0, 4'd0, 16'h0000, 10'd0,   3'd0, 16'h0000, 8'd10}, // R10 nop
    '{4'd2, 4'd0, 16'h0000, 10'd7,   3'd1, 16'h1234, 8'd2},  // R2 read forwarded
    '{4'd2, 4'd1, 16'h0000, 10'd9,   3'd4, 16'h0000, 8'd5},  // R5 R9 early col
    '{4'd3, 4'd1, 16'h0000, 10'd9,   3'd1, 16'h0042, 8'd5},  // R5 exactly T_RCD
    '{4'd4, 4'd0, 16'h0000, 10'd0,   3'd0, 16'h0000, 8'd3},  // R3 precharge
    '{4'd5, 4'd0, 16'h0000, 10'd0,   3'd0, 16'h0000, 8'd3},  // R3 precharge all
    '{4'd6, 4'd0, 16'h0000, 10'd0,   3'd0, 16'h0000, 8'd3},  // R3 refresh
    '{4'd2, 4'd0, 16'h0000, 10'h3FF, 3'd1, 16'h1234, 8'd3},  // R3 row kept
    '{4'd2, 4'd0, 16'h0000, 10'd1,   3'd5, 16'h0000, 8'd7},  // R7 col gap 1
    '{4'd1, 4'd0, 16'h1234, 10'd0,   3'd0, 16'h0000, 8'd4},  // R4 same row
    '{4'd2, 4'd0, 16'h0000, 10'd2,   3'd1, 16'h1234, 8'd4},  // R4 no restart
    '{4'd1, 4'd0, 16'h5555, 10'd0,   3'd0, 16'h0000, 8'd4},  // R4 new row
    '{4'd2, 4'd0, 16'h0000, 10'd3,   3'd4, 16'h0000, 8'd4},  // R4 restarted delay
    '{4'd0, 4'd0, 16'h0000, 10'd0,   3'd0, 16'h0000, 8'd4},
    '{4'd0, 4'd0, 16'h0000, 10'd0,   3'd0, 16'h0000, 8'd4},
    '{4'd2, 4'd0, 16'h0000, 10'd4,   3'd1, 16'h5555, 8'd4},  // R4 new row read
    '{4'd7, 4'd0, 16'h0000, 10'd0,   3'd0, 16'h0000, 8'd8},  // R8 enter
    '{4'd1, 4'd2, 16'h0007, 10'd0,   3'd2, 16'h0000, 8'd8},  // R8 act refused
    '{4'd2, 4'd0, 16'h0000, 10'd1,   3'd2, 16'h0000, 8'd8},  // R8 read refused
    '{4'd6, 4'd0, 16'h0000, 10'd0,   3'd2, 16'h0000, 8'd8},  // R8 refresh refused
    '{4'd7, 4'd0, 16'h0000, 10'd0,   3'd2, 16'h0000, 8'd8},  // R8 double entry
    '{4'd8, 4'd0, 16'h0000, 10'd0,   3'd0, 16'h0000, 8'd8},  // R8 exit
    '{4'd2, 4'd1, 16'h0000, 10'd6,   3'd1, 16'h0042, 8'd8},  // R8 rows intact
    '{4'd8, 4'd0, 16'h0000, 10'd0,   3'd2, 16'h0000, 8'd8},  // R8 stray exit
    '{4'd15, 4'd0, 16'h0000, 10'd0,  3'd0, 16'h0000, 8'd10}  // R10 unknown code
  };

  task automatic step(input logic [3:0] op, input logic [3:0] b,
                      input logic [15:0] r, input logic [9:0] c);
    cmd_op = op; cmd_bank = b; cmd_row = r; cmd_col = c;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 4'd0;
  endtask

  task automatic expect_res(input int kind, input logic [3:0] b, input logic [15:0] r,
                            input logic [9:0] c, input logic w, input int req);
    logic [4:0] got, want;
    got  = {acc_valid, err_mode, err_unopened, err_timing, err_spacing};
    want = {kind == E_FWD, kind == E_MODE, kind == E_UNOP, kind == E_TIME, kind == E_SPAC};
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL R%0d outcome {fwd,mode,unop,time,spac} got=%b exp=%b", req, got, want);
    end else if (kind == E_FWD && {acc_bank, acc_row, acc_col, acc_write} !== {b, r, c, w}) begin
      errors++;
      $display("FAIL R%0d access got bank=%0d row=%h col=%h wr=%b exp bank=%0d row=%h col=%h wr=%b",
               req, acc_bank, acc_row, acc_col, acc_write, b, r, c, w);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_op = 4'd0; cmd_bank = '0; cmd_row = '0; cmd_col = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_res(E_NONE, 4'd0, 16'd0, 10'd0, 1'b0, 1);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      step(VEC[i].op, VEC[i].bank, VEC[i].row, VEC[i].col);
      expect_res(int'(VEC[i].kind), VEC[i].bank, VEC[i].erow, VEC[i].col,
                 VEC[i].op == 4'd3, int'(VEC[i].req));
    end

    // R6 eight activates at the minimum gap, then one too close
    for (int k = 0; k < 8; k++) begin
      step(4'd1, 4'(2 + k), 16'h0100 + 16'(k), 10'd0);
      expect_res(E_NONE, 4'd0, 16'd0, 10'd0, 1'b0, 6);
      if (k < 7) step(4'd0, 4'd0, 16'd0, 10'd0);
    end
    step(4'd1, 4'd10, 16'h0200, 10'd0);
    expect_res(E_SPAC, 4'd0, 16'd0, 10'd0, 1'b0, 6);
    step(4'd0, 4'd0, 16'd0, 10'd0);
    step(4'd0, 4'd0, 16'd0, 10'd0);
    step(4'd0, 4'd0, 16'd0, 10'd0);
    step(4'd2, 4'd9, 16'd0, 10'h011);
    expect_res(E_FWD, 4'd9, 16'h0107, 10'h011, 1'b0, 6);
    step(4'd2, 4'd10, 16'd0, 10'h012);  // R6 refused activate left bank10 closed
    expect_res(E_UNOP, 4'd0, 16'd0, 10'd0, 1'b0, 6);

    // R1 reset clears every open row
    rst_n = 1'b0;
    @(negedge clk);
    expect_res(E_NONE, 4'd0, 16'd0, 10'd0, 1'b0, 1);
    checks++;
    if (acc_row !== 16'd0 || acc_bank !== 4'd0) begin
      errors++;
      $display("FAIL R1 reset fields got bank=%0d row=%h exp 0/0", acc_bank, acc_row);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(4'd2, 4'd9, 16'd0, 10'd1);
    expect_res(E_UNOP, 4'd0, 16'd0, 10'd0, 1'b0, 1);

    // R9 mode error outranks unopened bank
    step(4'd7, 4'd0, 16'd0, 10'd0);
    expect_res(E_NONE, 4'd0, 16'd0, 10'd0, 1'b0, 9);
    step(4'd2, 4'd5, 16'd0, 10'd1);
    expect_res(E_MODE, 4'd0, 16'd0, 10'd0, 1'b0, 9);
    step(4'd8, 4'd0, 16'd0, 10'd0);
    expect_res(E_NONE, 4'd0, 16'd0, 10'd0, 1'b0, 8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule